// File: doc/BRIEF.md
# Synchronous Serial Master Port

This block is a half-duplex serial master for clocked transfers. It drives a shift clock on `ck_o` and moves 8-bit or 9-bit words over one data line. The line is split into an output value `dt_o`, an output enable `dt_oe_o` and a sampled input `dt_i`, ready for a tristate pad. For transmission, a one-word holding register feeds a shift register, so a second word can be queued while the first is on the wire. Words then follow each other with no gap in the clock. For reception, the master keeps clocking and samples the line. Each completed word goes into a two-entry receive queue.

Reception runs in one of two modes. In single-word mode, a pulse on `sngl_set_i` arms the receiver for one word, and the arm flag clears itself once the word has landed. In continuous mode, words are received for as long as `cont_en_i` stays high, and this mode wins when both are active. A request to receive that arrives while a word is being sent cuts the transmission short. The clock half period comes from one programmable divider used by both directions.

Top module: `sync_serial_master`

## Requirements
- R1: After reset, `ck_o` is 0, `dt_oe_o` is 0, the holding register is empty (`tx_hold_empty_o`=1), the shifter is idle (`tx_idle_o`=1), the receive queue is empty, and `rx_ovr_o` and `sngl_en_o` are 0.
- R2: Each half period of `ck_o` lasts `div_i`+1 clock cycles. `ck_o` stays low whenever no word is moving.
- R3: A transmitted word goes out LSB first. Bit k is driven on the (k+1)-th rising `ck_o` edge after the shift register is loaded, and it is held unchanged through the falling edge that follows. With `nine_bit_i`=1 the word has 9 bits (bit 8 last); otherwise it has 8.
- R4: A word written into an empty holding register while the shifter is idle moves into the shift register on the next cycle, so `tx_hold_empty_o` returns to 1 and `tx_idle_o` goes to 0. A write while the holding register is full is ignored.
- R5: If the holding register is full when a word ends, the next word's first bit is driven on the very next rising edge, so consecutive rising edges stay exactly 2·(`div_i`+1) cycles apart.
- R6: `dt_oe_o` is 1 only while a word is being transmitted. It drops at the rising-edge slot after the last bit when no word is waiting.
- R7: During reception `dt_i` is sampled on each falling `ck_o` edge, LSB first. An 8-bit word is delivered with `rx_data_o[8]`=0.
- R8: A `sngl_set_i` pulse sets `sngl_en_o`. One word is then received, `sngl_en_o` clears in the same cycle that the word becomes readable, and `ck_o` stays low afterwards.
- R9: While `cont_en_i` is 1, words are received back to back with an unbroken clock. If single mode is also armed, reception continues after `sngl_en_o` clears. Dropping `cont_en_i` stops the clock.
- R10: A receive request during transmission abandons the word in the shift register, releases DT within two cycles, and receives one word.
- R11: Received words are read in arrival order: `rx_avail_o` flags a word at `rx_data_o`, and a one-cycle `rx_rd_i` pulse removes it. The queue holds two words.
- R12: A word that completes while the queue is full is discarded and sets `rx_ovr_o`. While `rx_ovr_o` is set, further words are discarded. `rx_ovr_o` clears only when `cont_en_i` falls from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_i | input | DIV_W | Clock half period minus one, in clk cycles |
| nine_bit_i | input | 1 | 1 selects 9-bit words, 0 selects 8-bit |
| tx_wr_i | input | 1 | Write strobe for the holding register |
| tx_data_i | input | 9 | Word to transmit |
| tx_hold_empty_o | output | 1 | Holding register can accept a word |
| tx_idle_o | output | 1 | No word is in the transmit shifter |
| sngl_set_i | input | 1 | Pulse that arms single-word reception |
| sngl_en_o | output | 1 | Single-word reception is armed |
| cont_en_i | input | 1 | Continuous reception enable |
| rx_rd_i | input | 1 | Removes the head word of the receive queue |
| rx_data_o | output | 9 | Head word of the receive queue |
| rx_avail_o | output | 1 | Receive queue is not empty |
| rx_ovr_o | output | 1 | Receive overrun flag |
| ck_o | output | 1 | Shift clock |
| dt_o | output | 1 | Data line output value |
| dt_oe_o | output | 1 | Data line output enable |
| dt_i | input | 1 | Data line input value |

## Verification
Two pairs of functions can land on the same clock edge. The end of one transmit word can coincide with loading the queued word, and the arming of single-word reception can coincide with an active transmission or with continuous mode. The bench provokes the first by writing a second word right after the first moves into the shifter, then checks that the rising-edge spacing stays constant across the word boundary. It provokes the second by pulsing the single-word arm a few bits into a transmission, and again together with the continuous enable. The pass criteria are that DT is released, the shifted word never reappears, and reception continues past the point where the arm flag clears itself.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
    localparam int WMAX = 9;

    typedef enum logic [1:0] {
        MD_IDLE = 2'd0,
        MD_TX   = 2'd1,
        MD_RX   = 2'd2
    } mode_e;

    typedef struct packed {
        mode_e             mode;
        logic              ck;
        logic              dt;
        logic              oe;
        logic [3:0]        bits;
        logic [WMAX-1:0]   shf;
        logic [WMAX-1:0]   hold;
        logic              hfull;
        logic              sngl;
        logic              cont;
        logic              ovr;
    } eng_t;
endpackage

// File: rtl/ssm_tick.sv
module ssm_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clr_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q >= div_i);
        if (!run_i || clr_i || tick_o) cnt_d = '0;
        else                           cnt_d = cnt_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_i != '0 && $stable(div_i)) |=> !tick_o);
endmodule

// File: rtl/ssm_rxq.sv
module ssm_rxq #(
    parameter int W     = 9,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] push_data_i,
    input  logic         pop_i,
    output logic [W-1:0] head_o,
    output logic         avail_o,
    output logic         full_o
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [CW-1:0]           cnt;
    } q_t;

    q_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pop_i && st_q.cnt != '0) begin
            for (int i = 0; i < DEPTH - 1; i++) st_d.mem[i] = st_q.mem[i+1];
            st_d.cnt = st_q.cnt - CW'(1);
        end
        if (push_i) begin
            for (int i = 0; i < DEPTH; i++)
                if (CW'(i) == st_d.cnt) st_d.mem[i] = push_data_i;
            st_d.cnt = st_d.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_o  = st_q.mem[0];
    assign avail_o = st_q.cnt != '0;
    assign full_o  = st_q.cnt == CW'(DEPTH);

    // R11
    rxq_no_overfill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);
    // R11
    rxq_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));
endmodule

// File: rtl/sync_serial_master.sv
module sync_serial_master
    import ssm_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int FIFO_DEPTH = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic            nine_bit_i,
    input  logic            tx_wr_i,
    input  logic [WMAX-1:0] tx_data_i,
    output logic            tx_hold_empty_o,
    output logic            tx_idle_o,
    input  logic            sngl_set_i,
    output logic            sngl_en_o,
    input  logic            cont_en_i,
    input  logic            rx_rd_i,
    output logic [WMAX-1:0] rx_data_o,
    output logic            rx_avail_o,
    output logic            rx_ovr_o,
    output logic            ck_o,
    output logic            dt_o,
    output logic            dt_oe_o,
    input  logic            dt_i
);
    eng_t            st_d, st_q;
    logic            tick, restart, push, q_full, rx_req;
    logic [3:0]      nbits;
    logic [WMAX-1:0] push_data;

    ssm_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run_i(st_q.mode != MD_IDLE),
        .clr_i(restart), .div_i(div_i), .tick_o(tick)
    );

    ssm_rxq #(.W(WMAX), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push_i(push), .push_data_i(push_data),
        .pop_i(rx_rd_i), .head_o(rx_data_o), .avail_o(rx_avail_o), .full_o(q_full)
    );

    always_comb begin
        st_d      = st_q;
        restart   = 1'b0;
        push      = 1'b0;
        nbits     = nine_bit_i ? 4'd9 : 4'd8;
        rx_req    = cont_en_i | st_q.sngl;
        push_data = nine_bit_i ? st_q.shf : {1'b0, st_q.shf[WMAX-1:1]};

        st_d.cont = cont_en_i;
        if (st_q.cont && !cont_en_i) st_d.ovr = 1'b0;
        if (sngl_set_i) st_d.sngl = 1'b1;
        if (tx_wr_i && !st_q.hfull) begin
            st_d.hold  = tx_data_i;
            st_d.hfull = 1'b1;
        end

        unique case (st_q.mode)
            MD_IDLE: begin
                if (rx_req) begin
                    st_d.mode = MD_RX;
                    st_d.bits = '0;
                end else if (st_q.hfull) begin
                    st_d.mode  = MD_TX;
                    st_d.shf   = st_q.hold;
                    st_d.hfull = 1'b0;
                    st_d.bits  = '0;
                end
            end
            MD_TX: begin
                if (rx_req) begin
                    st_d.mode = MD_RX;
                    st_d.bits = '0;
                    st_d.ck   = 1'b0;
                    st_d.oe   = 1'b0;
                    restart   = 1'b1;
                end else if (tick) begin
                    if (st_q.ck) begin
                        st_d.ck   = 1'b0;
                        st_d.bits = st_q.bits + 4'd1;
                    end else if (st_q.bits < nbits) begin
                        st_d.ck  = 1'b1;
                        st_d.oe  = 1'b1;
                        st_d.dt  = st_q.shf[0];
                        st_d.shf = st_q.shf >> 1;
                    end else if (st_q.hfull) begin
                        st_d.ck    = 1'b1;
                        st_d.oe    = 1'b1;
                        st_d.dt    = st_q.hold[0];
                        st_d.shf   = st_q.hold >> 1;
                        st_d.hfull = 1'b0;
                        st_d.bits  = '0;
                    end else begin
                        st_d.mode = MD_IDLE;
                        st_d.oe   = 1'b0;
                    end
                end
            end
            MD_RX: begin
                if (!rx_req) begin
                    st_d.mode = MD_IDLE;
                    st_d.ck   = 1'b0;
                end else if (tick) begin
                    if (st_q.ck) begin
                        st_d.ck   = 1'b0;
                        st_d.shf  = {dt_i, st_q.shf[WMAX-1:1]};
                        st_d.bits = st_q.bits + 4'd1;
                    end else if (st_q.bits < nbits) begin
                        st_d.ck = 1'b1;
                    end else begin
                        if (q_full) st_d.ovr = 1'b1;
                        else if (!st_q.ovr) push = 1'b1;
                        st_d.sngl = 1'b0;
                        st_d.bits = '0;
                        if (cont_en_i) st_d.ck = 1'b1;
                        else           st_d.mode = MD_IDLE;
                    end
                end
            end
            default: st_d.mode = MD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_hold_empty_o = !st_q.hfull;
    assign tx_idle_o       = st_q.mode != MD_TX;
    assign sngl_en_o       = st_q.sngl;
    assign rx_ovr_o        = st_q.ovr;
    assign ck_o            = st_q.ck;
    assign dt_o            = st_q.dt;
    assign dt_oe_o         = st_q.oe;

    // R2
    ck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MD_IDLE) |-> !st_q.ck);
    // R6
    oe_only_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.oe |-> (st_q.mode == MD_TX));
    // R3
    dt_stable_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(st_q.ck) && st_q.oe) |-> $stable(st_q.dt));
    // R12
    ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.ovr) |-> $fell(st_q.cont));
    // R8
    sngl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.sngl) |-> ($past(st_q.mode) == MD_RX));
    // R10
    rx_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MD_TX && (cont_en_i || st_q.sngl)) |=> (st_q.mode == MD_RX));
endmodule

// File: tb/sync_serial_master_bench.sv
module sync_serial_master_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 3;
    localparam int HALF       = DIV + 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_i = 8'(DIV);
    logic       nine_bit_i = 1'b0;
    logic       tx_wr_i = 1'b0;
    logic [8:0] tx_data_i = '0;
    logic       tx_hold_empty_o, tx_idle_o;
    logic       sngl_set_i = 1'b0;
    logic       sngl_en_o;
    logic       cont_en_i = 1'b0;
    logic       rx_rd_i = 1'b0;
    logic [8:0] rx_data_o;
    logic       rx_avail_o, rx_ovr_o;
    logic       ck_o, dt_o, dt_oe_o;
    logic       dt_i = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_serial_master u_sync_serial_master (
        .clk(clk), .rst_n(rst_n), .div_i(div_i), .nine_bit_i(nine_bit_i),
        .tx_wr_i(tx_wr_i), .tx_data_i(tx_data_i), .tx_hold_empty_o(tx_hold_empty_o),
        .tx_idle_o(tx_idle_o), .sngl_set_i(sngl_set_i), .sngl_en_o(sngl_en_o),
        .cont_en_i(cont_en_i), .rx_rd_i(rx_rd_i), .rx_data_o(rx_data_o),
        .rx_avail_o(rx_avail_o), .rx_ovr_o(rx_ovr_o), .ck_o(ck_o), .dt_o(dt_o),
        .dt_oe_o(dt_oe_o), .dt_i(dt_i)
    );

    // clock edge monitor
    int   cyc = 0, rise_n = 0, last_rise = 0, iv_min = 1000, iv_max = 0, hi_len = 0;
    logic mon_clr = 1'b0, ck_p = 1'b0;
    always @(negedge clk) begin
        cyc++;
        if (mon_clr) begin
            rise_n = 0; iv_min = 1000; iv_max = 0;
        end else begin
            if (!ck_p && ck_o) begin
                if (rise_n > 0) begin
                    if (cyc - last_rise < iv_min) iv_min = cyc - last_rise;
                    if (cyc - last_rise > iv_max) iv_max = cyc - last_rise;
                end
                rise_n++;
                last_rise = cyc;
            end
            if (ck_p && !ck_o) hi_len = cyc - last_rise;
        end
        ck_p = ck_o;
    end

    // receive-side peer: new bit after each rising edge while DT is released
    logic [63:0] slave_bits = '0;
    logic        slave_on = 1'b0;
    int          slave_idx = 0;
    always begin
        @(posedge ck_o or negedge slave_on);
        if (!slave_on) slave_idx = 0;
        else begin
            @(negedge clk);
            if (!dt_oe_o && slave_idx < 64) begin
                dt_i = slave_bits[slave_idx];
                slave_idx++;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic mclr();
        mon_clr = 1'b1;
        repeat (2) @(negedge clk);
        mon_clr = 1'b0;
    endtask

    task automatic wr(input logic [8:0] d);
        tx_data_i = d;
        tx_wr_i   = 1'b1;
        @(negedge clk);
        tx_wr_i   = 1'b0;
    endtask

    task automatic rd();
        rx_rd_i = 1'b1;
        @(negedge clk);
        rx_rd_i = 1'b0;
    endtask

    task automatic pulse_sngl();
        sngl_set_i = 1'b1;
        @(negedge clk);
        sngl_set_i = 1'b0;
    endtask

    task automatic next_fall(input int lim, output logic b, output logic oe, output logic ok);
        logic p = ck_o;
        ok = 1'b0; b = 1'b0; oe = 1'b0;
        for (int t = 0; t < lim; t++) begin
            @(negedge clk);
            if (p && !ck_o) begin
                b = dt_o; oe = dt_oe_o; ok = 1'b1;
                return;
            end
            p = ck_o;
        end
    endtask

    task automatic tx_get(input int nb, output logic [17:0] v, output int oe_bad);
        logic b, oe, ok;
        v = '0; oe_bad = 0;
        for (int i = 0; i < nb; i++) begin
            next_fall(200, b, oe, ok);
            if (!ok || !oe) oe_bad++;
            v[i] = b;
        end
    endtask

    task automatic wait_avail(output logic ok);
        ok = 1'b0;
        for (int t = 0; t < 1000; t++) begin
            @(negedge clk);
            if (rx_avail_o) begin ok = 1'b1; return; end
        end
    endtask

    task automatic flush();
        for (int t = 0; t < 4; t++) if (rx_avail_o) rd();
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 ck_o", ck_o, 0);
        chk("R1 dt_oe_o", dt_oe_o, 0);
        chk("R1 hold empty", tx_hold_empty_o, 1);
        chk("R1 tx idle", tx_idle_o, 1);
        chk("R1 rx_avail", rx_avail_o, 0);
        chk("R1 rx_ovr", rx_ovr_o, 0);
        chk("R1 sngl_en", sngl_en_o, 0);
    endtask

    task automatic t_tx_single();
        logic [17:0] v; int bad;
        nine_bit_i = 1'b0;
        mclr();
        wr(9'h0A5);
        @(negedge clk);
        chk("R4 hold moved", tx_hold_empty_o, 1);
        chk("R4 shifter busy", tx_idle_o, 0);
        tx_get(8, v, bad);
        chk("R3 8-bit word", int'(v[7:0]), 'hA5);
        chk("R6 oe during word", bad, 0);
        chk("R2 high time", hi_len, HALF);
        chk("R2 period min", iv_min, 2*HALF);
        chk("R2 period max", iv_max, 2*HALF);
        repeat (2*HALF + 2) @(negedge clk);
        chk("R6 released", dt_oe_o, 0);
        chk("R2 ck idle low", ck_o, 0);
        chk("R3 shifter idle", tx_idle_o, 1);
    endtask

    task automatic t_tx_b2b();
        logic [17:0] v; int bad;
        nine_bit_i = 1'b1;
        mclr();
        wr(9'h1C3);
        @(negedge clk);
        wr(9'h05A);
        tx_get(18, v, bad);
        chk("R3 9-bit first", int'(v[8:0]), 'h1C3);
        chk("R5 9-bit second", int'(v[17:9]), 'h05A);
        chk("R5 oe held", bad, 0);
        chk("R5 rise count", rise_n, 18);
        chk("R5 spacing min", iv_min, 2*HALF);
        chk("R5 spacing max", iv_max, 2*HALF);
        repeat (2*HALF + 2) @(negedge clk);
        chk("R6 released b2b", dt_oe_o, 0);
        nine_bit_i = 1'b0;
    endtask

    task automatic t_tx_drop();
        logic [17:0] v; int bad; logic b, oe, ok;
        nine_bit_i = 1'b0;
        wr(9'h03C);
        @(negedge clk);
        wr(9'h0E1);
        wr(9'h077);
        chk("R4 hold full", tx_hold_empty_o, 0);
        tx_get(16, v, bad);
        chk("R4 first word", int'(v[7:0]), 'h3C);
        chk("R4 second word", int'(v[15:8]), 'hE1);
        next_fall(120, b, oe, ok);
        chk("R4 full write ignored", ok, 0);
    endtask

    task automatic t_rx_single();
        logic ok;
        nine_bit_i = 1'b1;
        slave_bits = 64'h15A;
        slave_on = 1'b1;
        @(negedge clk);
        pulse_sngl();
        chk("R8 armed", sngl_en_o, 1);
        wait_avail(ok);
        chk("R8 word arrived", ok, 1);
        chk("R7 9-bit data", int'(rx_data_o), 'h15A);
        chk("R8 self clear", sngl_en_o, 0);
        repeat (20) @(negedge clk);
        chk("R8 ck stopped", ck_o, 0);
        rd();
        chk("R11 empty after read", rx_avail_o, 0);
        slave_on = 1'b0;
        nine_bit_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_rx_overrun();
        logic ok = 1'b0;
        slave_bits = 64'h0000_0000_0081_C33C;
        slave_on = 1'b1;
        mclr();
        cont_en_i = 1'b1;
        for (int t = 0; t < 1500 && !ok; t++) begin
            @(negedge clk);
            ok = rx_ovr_o;
        end
        chk("R12 overrun set", ok, 1);
        chk("R11 first word", int'(rx_data_o), 'h3C);
        rd();
        chk("R11 second word", int'(rx_data_o), 'hC3);
        rd();
        repeat (150) @(negedge clk);
        chk("R12 words dropped", rx_avail_o, 0);
        chk("R12 overrun held", rx_ovr_o, 1);
        chk("R9 continuous spacing min", iv_min, 2*HALF);
        chk("R9 continuous spacing max", iv_max, 2*HALF);
        cont_en_i = 1'b0;
        repeat (2) @(negedge clk);
        chk("R12 overrun cleared", rx_ovr_o, 0);
        chk("R9 ck stops", ck_o, 0);
        flush();
        slave_on = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_prec();
        logic ok;
        slave_bits = 64'h2211;
        slave_on = 1'b1;
        @(negedge clk);
        cont_en_i = 1'b1;
        pulse_sngl();
        wait_avail(ok);
        chk("R9 first arrived", ok, 1);
        chk("R9 single cleared", sngl_en_o, 0);
        chk("R9 first data", int'(rx_data_o), 'h11);
        rd();
        wait_avail(ok);
        chk("R9 continues", ok, 1);
        chk("R9 second data", int'(rx_data_o), 'h22);
        cont_en_i = 1'b0;
        repeat (3) @(negedge clk);
        flush();
        slave_on = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_interrupt();
        logic b, oe, ok;
        slave_bits = 64'h96;
        wr(9'h00F);
        for (int i = 0; i < 3; i++) next_fall(200, b, oe, ok);
        slave_on = 1'b1;
        pulse_sngl();
        repeat (2) @(negedge clk);
        chk("R10 DT released", dt_oe_o, 0);
        chk("R10 shifter left", tx_idle_o, 1);
        wait_avail(ok);
        chk("R10 word received", ok, 1);
        chk("R10 data", int'(rx_data_o), 'h96);
        chk("R10 single cleared", sngl_en_o, 0);
        repeat (40) @(negedge clk);
        chk("R10 no resume ck", ck_o, 0);
        chk("R10 no resume oe", dt_oe_o, 0);
        rd();
        slave_on = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_tx_single();
        t_tx_b2b();
        t_tx_drop();
        t_rx_single();
        t_rx_overrun();
        t_prec();
        t_interrupt();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule